// File: doc/BRIEF.md
# Operand Address Resolver

This block maps one operand reference of an 8-bit controller onto a physical location. It takes an addressing-mode code, an operand byte and the register-bank bits, together with the current values of the two pointer registers, the accumulator and the 16-bit data pointer. From these it works out which space is addressed: on-chip data RAM, special-function-register space, external data memory or program memory. It also works out the address inside that space.

Each request is resolved into a registered result one clock later. The result is an address, a space code and a valid flag. External data accesses also produce active-low read or write strobes lasting one cycle. Two error flags report an indirect internal pointer outside on-chip RAM and a write attempt in indexed mode. Neither error case produces any access. Instruction decode, the memories and the register contents themselves sit outside the block.

Top module: `oar_resolver`

## Requirements
- R1: While reset is asserted and on the first edge after it, `acc_valid` is 0, `rd_n` and `wr_n` are 1, and both error flags are 0.
- R2: Mode 0 (register) resolves to on-chip RAM (space code 0) at address {bank[1:0], operand[2:0]}, with the upper address bits zero.
- R3: Mode 1 (direct) resolves operand values 00h–7Fh to on-chip RAM (space 0) and values 80h–FFh to SFR space (space 1), at the operand value.
- R4: Mode 2 (internal indirect) uses R1 when operand[0]=1 and R0 otherwise, and targets on-chip RAM (space 0). A pointer value of 80h or above raises `err_range` with `acc_valid` 0 and no strobe.
- R5: Mode 3 (external indirect) targets external data (space 2). When operand[1]=1 the address is the data pointer; otherwise it is {00h, Ri}, with Ri chosen by operand[0] as in R4.
- R6: A mode-3 read drives `rd_n` low, and a mode-3 write drives `wr_n` low. The two strobes are never low together. Each strobe lasts exactly one cycle per request and returns high on the following idle cycle.
- R7: Mode 4 (indexed) read resolves to program memory (space 3) at (A + DPTR) modulo 65536, with no strobe.
- R8: A write request in mode 4 raises `err_write`, keeps `acc_valid` at 0, and never drives `wr_n` low.
- R9: Results appear on the clock edge after the request. A cycle without `req`, or a request with mode code 5–7, yields `acc_valid` 0 with no strobe and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Resolve request this cycle |
| req_we | input | 1 | Request is a write |
| mode | input | 3 | Addressing mode code (0 reg, 1 direct, 2 int. indirect, 3 ext. indirect, 4 indexed) |
| operand | input | 8 | Operand byte or register/pointer select field |
| bank | input | 2 | Register bank select bits |
| r0_val | input | 8 | Current-bank R0 contents |
| r1_val | input | 8 | Current-bank R1 contents |
| acc | input | 8 | Accumulator contents |
| dptr | input | 16 | Data pointer contents |
| acc_valid | output | 1 | Resolved access is valid |
| acc_space | output | 2 | Target space: 0 RAM, 1 SFR, 2 external data, 3 program |
| acc_addr | output | 16 | Resolved address |
| rd_n | output | 1 | External data read strobe, active low |
| wr_n | output | 1 | External data write strobe, active low |
| err_range | output | 1 | Internal indirect pointer out of on-chip RAM |
| err_write | output | 1 | Write attempted in indexed mode |

## Verification
The bench builds the block with its default parameters: a 16-bit address and 128 bytes of on-chip RAM. With these values, the 7Fh/80h boundary is reached in both direct and internal-indirect modes, and the indexed sum can wrap past FFFFh. All four register banks and both pointer registers are driven. Back-to-back and isolated external requests expose the one-cycle strobe width.

// File: rtl/oar_resolver.sv
module oar_resolver #(
  parameter int ADDR_W     = 16,
  parameter int IRAM_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [2:0]        mode,
  input  logic [7:0]        operand,
  input  logic [1:0]        bank,
  input  logic [7:0]        r0_val,
  input  logic [7:0]        r1_val,
  input  logic [7:0]        acc,
  input  logic [ADDR_W-1:0] dptr,
  output logic              acc_valid,
  output logic [1:0]        acc_space,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              rd_n,
  output logic              wr_n,
  output logic              err_range,
  output logic              err_write
);
  localparam logic [1:0] SP_IRAM = 2'd0, SP_SFR = 2'd1, SP_XDATA = 2'd2, SP_CODE = 2'd3;
  localparam logic [ADDR_W-1:0] IRAM_LIM = ADDR_W'(IRAM_BYTES);

  logic [7:0]        ptr;
  logic [ADDR_W-1:0] n_addr;
  logic [1:0]        n_space;
  logic              n_valid, n_rng, n_wer, n_rd, n_wr;

  assign ptr = operand[0] ? r1_val : r0_val;

  always_comb begin
    n_addr  = '0;
    n_space = SP_IRAM;
    n_valid = 1'b0;
    n_rng   = 1'b0;
    n_wer   = 1'b0;
    n_rd    = 1'b0;
    n_wr    = 1'b0;
    if (req) begin
      case (mode)
        3'd0: begin
          n_addr  = ADDR_W'({bank, operand[2:0]});
          n_valid = 1'b1;
        end
        3'd1: begin
          n_addr  = ADDR_W'(operand);
          n_space = (ADDR_W'(operand) < IRAM_LIM) ? SP_IRAM : SP_SFR;
          n_valid = 1'b1;
        end
        3'd2: begin
          n_addr = ADDR_W'(ptr);
          if (ADDR_W'(ptr) < IRAM_LIM) n_valid = 1'b1;
          else                         n_rng   = 1'b1;
        end
        3'd3: begin
          n_addr  = operand[1] ? dptr : ADDR_W'(ptr);
          n_space = SP_XDATA;
          n_valid = 1'b1;
          n_rd    = !req_we;
          n_wr    = req_we;
        end
        3'd4: begin
          n_addr  = dptr + ADDR_W'(acc);
          n_space = SP_CODE;
          n_valid = !req_we;
          n_wer   = req_we;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_space <= SP_IRAM;
      acc_addr  <= '0;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      err_range <= 1'b0;
      err_write <= 1'b0;
    end else begin
      acc_valid <= n_valid;
      acc_space <= n_space;
      acc_addr  <= n_addr;
      rd_n      <= !n_rd;
      wr_n      <= !n_wr;
      err_range <= n_rng;
      err_write <= n_wer;
    end
  end
endmodule

module oar_resolver_chk #(
  parameter int ADDR_W     = 16,
  parameter int IRAM_BYTES = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              req_we,
  input logic [2:0]        mode,
  input logic [7:0]        operand,
  input logic [1:0]        bank,
  input logic              acc_valid,
  input logic [1:0]        acc_space,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              rd_n,
  input logic              wr_n,
  input logic              err_range,
  input logic              err_write
);
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r6_rd_from_ext_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(req && mode == 3'd3 && !req_we));
  a_r6_wr_from_ext_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> acc_space == 2'd2 && acc_valid);
  a_r2_reg_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode == 3'd0 |=> acc_valid && acc_space == 2'd0 &&
      acc_addr == ADDR_W'({$past(bank), $past(operand[2:0])}));
  a_r4_range_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    err_range |-> !acc_valid && rd_n && wr_n);
  a_r8_no_code_write: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode == 3'd4 && req_we |=> err_write && !acc_valid && wr_n);
  a_r7_code_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_space == 2'd3 |-> rd_n && wr_n);
  a_r9_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !acc_valid && rd_n && wr_n && !err_range && !err_write);
endmodule

bind oar_resolver oar_resolver_chk #(.ADDR_W(ADDR_W), .IRAM_BYTES(IRAM_BYTES)) u_chk (.*);

// File: tb/tb_oar_resolver.sv
`timescale 1ns/1ps
module tb_oar_resolver;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [2:0] mode = '0;
  logic [7:0] operand = '0, r0_val = '0, r1_val = '0, acc = '0;
  logic [1:0] bank = '0;
  logic [15:0] dptr = '0;
  logic acc_valid, rd_n, wr_n, err_range, err_write;
  logic [1:0] acc_space;
  logic [15:0] acc_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  oar_resolver dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] m, logic [7:0] op, logic we);
    @(negedge clk);
    req = 1'b1; mode = m; operand = op; req_we = we;
    @(posedge clk); #1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_acc(string tag, logic v, logic [1:0] sp, logic [15:0] a,
                            logic r, logic w, logic er, logic ew);
    chk({tag, " valid"}, acc_valid, v);
    if (v) begin
      chk({tag, " space"}, acc_space, sp);
      chk({tag, " addr"}, acc_addr, a);
    end
    chk({tag, " rd_n"}, rd_n, r);
    chk({tag, " wr_n"}, wr_n, w);
    chk({tag, " err_range"}, err_range, er);
    chk({tag, " err_write"}, err_write, ew);
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_acc("R1 in reset", 0, 0, 0, 1, 1, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    expect_acc("R1 after reset", 0, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_register;
    for (int b = 0; b < 4; b++) begin
      bank = 2'(b);
      issue(3'd0, 8'hF8 | 8'(b * 2 + 1), 0);
      expect_acc("R2 reg", 1, 0, 16'(b * 8 + b * 2 + 1), 1, 1, 0, 0);
    end
  endtask

  task automatic t_direct;
    issue(3'd1, 8'h7F, 0); expect_acc("R3 direct 7F", 1, 0, 16'h007F, 1, 1, 0, 0);
    issue(3'd1, 8'h80, 0); expect_acc("R3 direct 80", 1, 1, 16'h0080, 1, 1, 0, 0);
    issue(3'd1, 8'hFF, 1); expect_acc("R3 direct FF", 1, 1, 16'h00FF, 1, 1, 0, 0);
    issue(3'd1, 8'h00, 0); expect_acc("R3 direct 00", 1, 0, 16'h0000, 1, 1, 0, 0);
  endtask

  task automatic t_ind_int;
    r0_val = 8'h45; r1_val = 8'h7F;
    issue(3'd2, 8'h00, 0); expect_acc("R4 @R0", 1, 0, 16'h0045, 1, 1, 0, 0);
    issue(3'd2, 8'h01, 1); expect_acc("R4 @R1", 1, 0, 16'h007F, 1, 1, 0, 0);
    r1_val = 8'h80;
    issue(3'd2, 8'h01, 0); expect_acc("R4 @R1 80h", 0, 0, 0, 1, 1, 1, 0);
    r0_val = 8'hC3;
    issue(3'd2, 8'h00, 1); expect_acc("R4 @R0 C3h", 0, 0, 0, 1, 1, 1, 0);
  endtask

  task automatic t_ind_ext;
    dptr = 16'hBEEF; r0_val = 8'h12; r1_val = 8'h34;
    issue(3'd3, 8'h02, 0); expect_acc("R5 @DPTR rd", 1, 2, 16'hBEEF, 0, 1, 0, 0);
    @(posedge clk); #1;
    expect_acc("R6 rd released", 0, 0, 0, 1, 1, 0, 0);
    issue(3'd3, 8'h01, 1); expect_acc("R5 @R1 wr", 1, 2, 16'h0034, 1, 0, 0, 0);
    @(posedge clk); #1;
    expect_acc("R6 wr released", 0, 0, 0, 1, 1, 0, 0);
    @(negedge clk);
    req = 1'b1; mode = 3'd3; operand = 8'h00; req_we = 1'b0;
    @(posedge clk); #1;
    expect_acc("R5 @R0 rd", 1, 2, 16'h0012, 0, 1, 0, 0);
    @(negedge clk); req_we = 1'b1; operand = 8'h02;
    @(posedge clk); #1;
    expect_acc("R6 back-to-back wr", 1, 2, 16'hBEEF, 1, 0, 0, 0);
    @(negedge clk); req = 1'b0;
    @(posedge clk); #1;
    expect_acc("R6 idle after pair", 0, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_indexed;
    acc = 8'h10; dptr = 16'hFFF8;
    issue(3'd4, 8'h00, 0); expect_acc("R7 wrap", 1, 3, 16'h0008, 1, 1, 0, 0);
    acc = 8'hFF; dptr = 16'h0300;
    issue(3'd4, 8'h00, 0); expect_acc("R7 sum", 1, 3, 16'h03FF, 1, 1, 0, 0);
    issue(3'd4, 8'h00, 1); expect_acc("R8 code write", 0, 0, 0, 1, 1, 0, 1);
  endtask

  task automatic t_idle;
    @(negedge clk); req = 1'b0; mode = 3'd3; req_we = 1'b1;
    @(posedge clk); #1;
    expect_acc("R9 no req", 0, 0, 0, 1, 1, 0, 0);
    for (int m = 5; m < 8; m++) begin
      issue(3'(m), 8'h55, 1);
      expect_acc("R9 unused mode", 0, 0, 0, 1, 1, 0, 0);
    end
  endtask

  initial begin
    t_reset();
    t_register();
    t_direct();
    t_ind_int();
    t_ind_ext();
    t_indexed();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule